// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

The block gathers a parameterised number of level-sensitive peripheral interrupt lines, arranged in words of 32. It drives one interrupt output to each of several CPUs. Every input passes through a two-flop synchroniser. Each CPU owns a private register bank holding a mask for every source. A CPU's output is asserted while any source that its bank leaves unmasked is high.

Software selects a bank with a CPU-select field. It then addresses one 32-bit word inside that bank. Each bank is laid out as four consecutive groups of `NUM_WORDS` registers, in this order: raw status, mask status, mask-set and mask-clear. Writes to the mask-set group and the mask-clear group change only the bits written as 1, so no read-modify-write is needed. There is no priority encoder, so a handler scans every status word to find its sources.

Top module: `lvl_irq_aggr`

## Requirements
- R1: Byte offset `(g*NUM_WORDS + w)*4` addresses word `w` of group `g`, where g=0 is status, g=1 is mask status, g=2 is mask-set and g=3 is mask-clear. A bank spans `16*NUM_WORDS` bytes. Bit `b` of word `w` is source `32*w + b`.
- R2: A status read returns the synchronised input levels, whatever the mask. An input change reaches the status register two clock edges after it is sampled.
- R3: A mask-status read returns the mask bits, where 1 means masked. After reset every mask bit in every bank is 1.
- R4: A write to a mask-set word sets each mask bit written as 1. Bits written as 0 keep their value.
- R5: A write to a mask-clear word clears each mask bit written as 1. Bits written as 0 keep their value.
- R6: The following writes leave every mask unchanged: writes to status or mask-status words, writes to offsets at or above `16*NUM_WORDS`, writes to offsets that are not word-aligned, and writes with a CPU select of `NUM_CPUS` or more.
- R7: `irq_o[c]` is a register. It holds the OR, over all words, of status AND NOT bank c's mask. It rises three edges after an unmasked input rises and falls again when that input falls.
- R8: A write with CPU select c changes only bank c. The same source can be unmasked in any chosen subset of banks.
- R9: Read data appears on `rdata_o` one cycle after the request. Reads of mask-set or mask-clear words, reads of out-of-range or unaligned offsets, and reads from an invalid CPU return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 32*NUM_WORDS | Asynchronous level interrupt sources |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| cpu_sel_i | input | CPU_W | Bank (CPU) select |
| addr_i | input | ADDR_W | Byte offset within the bank |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | NUM_CPUS | Per-CPU interrupt output |

## Verification
A mask-clear write can land in the same cycle that the source it unmasks rises at the input. The output may then be asserted only after the synchroniser has delivered the level, not on the earlier mask update. The bench writes the mask-clear and raises the source on the same falling edge. It then checks that `irq_o` stays low after two edges and is high after the third. A sweep also unmasks every source alone in each bank in turn. After each step the bench checks that only that bank's output rises and that a mask-set write drops it again.

// File: rtl/lia_pkg.sv
package lia_pkg;
  localparam int WORD_BITS = 32;
  typedef enum logic [1:0] {
    GRP_STAT  = 2'd0,
    GRP_MSTAT = 2'd1,
    GRP_MSET  = 2'd2,
    GRP_MCLR  = 2'd3
  } grp_e;
endpackage

// File: rtl/lia_sync.sv
module lia_sync #(
  parameter int W = 96
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      warm_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
  end

  assign q_o = s2_q;

  // R2: two-edge latency, once both stages hold post-reset samples
  a_r2_two_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/lia_decode.sv
module lia_decode
  import lia_pkg::*;
#(
  parameter int NW     = 3,
  parameter int ADDR_W = 6,
  parameter int WW     = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output grp_e              grp_o,
  output logic [WW-1:0]     word_o
);
  localparam int SPAN = 16 * NW;

  int unsigned idx, base;

  always_comb begin
    idx     = 32'(addr_i) >> 2;
    valid_o = (32'(addr_i) < SPAN) && (addr_i[1:0] == 2'b00);
    if (idx >= 3 * NW) begin
      grp_o = GRP_MCLR;  base = 3 * NW;
    end else if (idx >= 2 * NW) begin
      grp_o = GRP_MSET;  base = 2 * NW;
    end else if (idx >= NW) begin
      grp_o = GRP_MSTAT; base = NW;
    end else begin
      grp_o = GRP_STAT;  base = 0;
    end
    word_o = WW'(idx - base);
  end
endmodule

// File: rtl/lia_bank.sv
module lia_bank
  import lia_pkg::*;
#(
  parameter int NW = 3,
  parameter int WW = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  grp_e                    grp_i,
  input  logic [WW-1:0]           word_i,
  input  logic [WORD_BITS-1:0]    wdata_i,
  input  logic [NW*WORD_BITS-1:0] status_i,
  output logic [NW*WORD_BITS-1:0] mask_o,
  output logic                    irq_o
);
  logic [NW-1:0][WORD_BITS-1:0] mask_q;
  logic                         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (wr_i) begin
      for (int w = 0; w < NW; w++) begin
        if (word_i == WW'(w)) begin
          if (grp_i == GRP_MSET)      mask_q[w] <= mask_q[w] | wdata_i;
          else if (grp_i == GRP_MCLR) mask_q[w] <= mask_q[w] & ~wdata_i;
        end
      end
    end
  end

  assign mask_o = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_i & ~mask_o);
  end

  assign irq_o = irq_q;

  for (genvar w = 0; w < NW; w++) begin : g_chk
    a_r4_set_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && grp_i == GRP_MSET && word_i == WW'(w)) |=>
        (((mask_q[w] & $past(wdata_i)) == $past(wdata_i)) &&
         ((mask_q[w] & ~$past(wdata_i)) == ($past(mask_q[w]) & ~$past(wdata_i)))));
    a_r5_clr_unmasks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && grp_i == GRP_MCLR && word_i == WW'(w)) |=>
        (((mask_q[w] & $past(wdata_i)) == '0) &&
         ((mask_q[w] & ~$past(wdata_i)) == ($past(mask_q[w]) & ~$past(wdata_i)))));
  end

  a_r6_ro_groups: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i || grp_i == GRP_STAT || grp_i == GRP_MSTAT) |=> $stable(mask_q));
  a_r7_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_i & ~mask_o) == '0) |=> !irq_o);
  a_r7_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_i & ~mask_o) != '0) |=> irq_o);
endmodule

// File: rtl/lvl_irq_aggr.sv
module lvl_irq_aggr
  import lia_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int NUM_CPUS  = 2,
  localparam int SRC_W    = NUM_WORDS * WORD_BITS,
  localparam int ADDR_W   = $clog2(16 * NUM_WORDS),
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SRC_W-1:0]     src_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [CPU_W-1:0]     cpu_sel_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [WORD_BITS-1:0] wdata_i,
  output logic [WORD_BITS-1:0] rdata_o,
  output logic [NUM_CPUS-1:0]  irq_o
);
  localparam int WW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  initial begin
    if (NUM_WORDS < 2 || NUM_WORDS > 5) $error("NUM_WORDS must be 2..5");
  end

  logic [SRC_W-1:0]                 status;
  logic [NUM_CPUS-1:0][SRC_W-1:0]   mask_all;
  logic [NUM_CPUS-1:0]              bank_wr;
  logic                             acc_ok;
  grp_e                             grp;
  logic [WW-1:0]                    word;
  logic [WORD_BITS-1:0]             rd_next, rdata_q;

  lia_sync #(.W(SRC_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (status)
  );

  lia_decode #(.NW(NUM_WORDS), .ADDR_W(ADDR_W), .WW(WW)) u_dec (
    .addr_i (addr_i),
    .valid_o(acc_ok),
    .grp_o  (grp),
    .word_o (word)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
    assign bank_wr[c] = req_i && we_i && acc_ok && (32'(cpu_sel_i) == c);

    lia_bank #(.NW(NUM_WORDS), .WW(WW)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (bank_wr[c]),
      .grp_i   (grp),
      .word_i  (word),
      .wdata_i (wdata_i),
      .status_i(status),
      .mask_o  (mask_all[c]),
      .irq_o   (irq_o[c])
    );

    a_r8_bank_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(req_i && we_i && (32'(cpu_sel_i) == c))) |=> $stable(mask_all[c]));
  end

  always_comb begin
    rd_next = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (32'(cpu_sel_i) == c && word == WW'(w)) begin
          if (grp == GRP_STAT)       rd_next = status[w*WORD_BITS +: WORD_BITS];
          else if (grp == GRP_MSTAT) rd_next = mask_all[c][w*WORD_BITS +: WORD_BITS];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rdata_q <= '0;
    else if (req_i && !we_i && acc_ok)  rdata_q <= rd_next;
    else if (req_i && !we_i)            rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  a_r9_bad_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (!acc_ok || 32'(cpu_sel_i) >= NUM_CPUS)) |=> (rdata_o == '0));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(req_i && !we_i)) |=> $stable(rdata_o));
endmodule

// File: tb/tb_lvl_irq_aggr.sv
module tb_lvl_irq_aggr;
  localparam int NW  = 3;
  localparam int NC  = 2;
  localparam int SW  = NW * 32;
  localparam int AW  = $clog2(16 * NW);
  localparam int CW  = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] src = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [CW-1:0] csel = '0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NC-1:0] irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] emask [NC][NW];

  always #4 clk = ~clk;

  lvl_irq_aggr #(.NUM_WORDS(NW), .NUM_CPUS(NC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .cpu_sel_i(csel), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [AW-1:0] off(int g, int w);
    return AW'((g * NW + w) * 4);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int c, logic [AW-1:0] a, logic [31:0] d);
    csel = CW'(c); addr = a; wdata = d; we = 1'b1; req = 1'b1;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(int c, logic [AW-1:0] a, output logic [31:0] d);
    csel = CW'(c); addr = a; we = 1'b0; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++)
        if ((src[w*32 +: 32] & ~emask[c][w]) != 0) r[c] = 1'b1;
    return r;
  endfunction

  task automatic chk_masks(string tag);
    logic [31:0] d;
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) begin
        rd(c, off(1, w), d);
        chk(tag, d, emask[c][w]);
      end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) emask[c][w] = '1;
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R3: reset masks all ones, irq low
    chk_masks("R3 reset mask");
    chk("R7 reset irq", 32'(irq), 32'(0));

    // R2: status follows inputs regardless of mask
    for (int w = 0; w < NW; w++) src[w*32 +: 32] = 32'hA5C3_0000 ^ (32'h1111_1111 * (w + 1));
    tick(3);
    for (int w = 0; w < NW; w++) begin
      rd(w % NC, off(0, w), d);
      chk("R2 status", d, 32'hA5C3_0000 ^ (32'h1111_1111 * (w + 1)));
    end
    chk("R7 all masked", 32'(irq), 32'(0));
    src = '0;
    tick(3);

    // R4/R5: atomic set/clear patterns
    wr(0, off(3, 1), 32'hF0F0_00FF); for (int i = 0; i < 1; i++) emask[0][1] &= ~32'hF0F0_00FF;
    wr(0, off(2, 1), 32'h0000_0F0F); emask[0][1] |= 32'h0000_0F0F;
    wr(1, off(3, 2), 32'hFFFF_0000); emask[1][2] &= ~32'hFFFF_0000;
    wr(1, off(2, 2), 32'h8000_0000); emask[1][2] |= 32'h8000_0000;
    wr(0, off(3, 0), 32'h0000_0001); emask[0][0] &= ~32'h1;
    chk_masks("R4 R5 set/clear");

    // R6: ignored writes
    wr(0, off(0, 1), 32'h0);
    wr(0, off(1, 1), 32'h0);
    wr(1, off(1, 0), 32'h0);
    wr(0, AW'(16 * NW), 32'hFFFF_FFFF);
    wr(0, AW'(16 * NW + 8), 32'hFFFF_FFFF);
    wr(0, off(3, 2) + AW'(1), 32'hFFFF_FFFF);
    chk_masks("R6 ignored writes");

    // R9: read-as-zero cases
    rd(0, off(2, 0), d); chk("R9 mset reads 0", d, 32'h0);
    rd(1, off(3, 1), d); chk("R9 mclr reads 0", d, 32'h0);
    rd(0, AW'(16 * NW + 4), d); chk("R9 out of range", d, 32'h0);
    rd(0, off(1, 0) + AW'(2), d); chk("R9 unaligned", d, 32'h0);

    // restore all masks
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) begin
        wr(c, off(2, w), 32'hFFFF_FFFF); emask[c][w] = '1;
      end

    // R7 same-cycle: mask clear with the source rising, irq after 3 edges
    csel = 1'b0; addr = off(3, 2); wdata = 32'h0000_0010; we = 1'b1; req = 1'b1;
    src[2*32 + 4] = 1'b1;
    emask[0][2] &= ~32'h10;
    tick(1); req = 1'b0; we = 1'b0;
    tick(1);
    chk("R7 early edge 2", 32'(irq), 32'(0));
    tick(1);
    chk("R7 at edge 3", 32'(irq), 32'(1));
    src[2*32 + 4] = 1'b0;
    tick(2);
    chk("R7 fall early", 32'(irq), 32'(1));
    tick(1);
    chk("R7 fall", 32'(irq), 32'(0));
    wr(0, off(2, 2), 32'h10); emask[0][2] |= 32'h10;

    // R1/R8: sweep every source in every bank
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < SW; s++) begin
        wr(c, off(3, s / 32), 32'(1) << (s % 32));
        emask[c][s / 32] &= ~(32'(1) << (s % 32));
        src = '0; src[s] = 1'b1;
        tick(3);
        chk("R8 R1 sweep on", 32'(irq), 32'(exp_irq()));
        wr(c, off(2, s / 32), 32'(1) << (s % 32));
        emask[c][s / 32] |= (32'(1) << (s % 32));
        tick(1);
        chk("R4 sweep off", 32'(irq), 32'(0));
        src = '0;
      end

    // R8: same source unmasked in both banks
    wr(0, off(3, 1), 32'h0000_0100); emask[0][1] &= ~32'h100;
    wr(1, off(3, 1), 32'h0000_0100); emask[1][1] &= ~32'h100;
    src[32 + 8] = 1'b1;
    tick(3);
    chk("R8 both banks", 32'(irq), 32'(exp_irq()));
    chk_masks("R8 masks");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule